// File: doc/BRIEF.md
# Blank-Synchronized Pixel Writer

This block is a bus master that paints a fixed test scene into a frame buffer of 8-bit colour pixels, one pixel per write transaction. It walks the screen as a raster, with the column index moving fastest, and it repeats the walk forever. Each visited pixel is classed as blue band, diagonal line, colour map or free area. A free pixel is stepped over without any bus traffic, so a second master can own that area. Every other pixel is written with a colour that follows from its class and position.

A new write may only start while the display is in its blanking interval, so the pixel traffic stays clear of the video read-out. The blanking input is active low and passes through a flip-flop synchronizer before it is used. Once a request is raised, its address and data stay fixed until the slave acknowledges it. The colour-map region takes its colour from a frame counter that advances each time a full frame has been walked, so the pattern drifts slowly across the screen.

The frame buffer, the bus interconnect and the video timing generator sit outside this block. With an acknowledge in the same cycle as the request, one pixel is written every two clock cycles. At a clock of about 12 MHz or more this exceeds 6 megapixels per second.

Top module: `pixel_writer_master`

## Requirements
- R1: While reset is held, and in the first cycle after it, `wr_req` is 0, and `wr_addr` and `wr_data` are 0. The scan position and the frame counter are cleared.
- R2: `wr_req` rises only when `vid_blank_n` was low at the clock edge two edges before the rising edge. This is the two-stage synchronizer delay at the default depth, where 0 means blanking.
- R3: While `wr_req` is 1 and `wr_ack` is 0, `wr_req`, `wr_addr` and `wr_data` keep their values into the next cycle.
- R4: `wr_addr` = y*H_PIX + x. Pixels are written in raster order with x fastest. Every non-free pixel is written exactly once per frame.
- R5: Rows y < BLUE_ROWS are written with BLUE_CODE (default 8'h03: blue in bits 1:0 of a 3-3-2 red-green-blue code).
- R6: Pixels with y >= V_PIX - FREE_ROWS and x < FREE_COLS are never written.
- R7: Outside the blue band and the free area, pixels with x == y are written with LINE_CODE (default 8'hFF).
- R8: All remaining pixels are written with (x + y + frame_count) mod 256. Over a row of 256 or more pixels this covers every 8-bit value.
- R9: The frame counter starts at 0 and goes up by one, mod 256, each time the last pixel of a frame is passed. A given map pixel is therefore written one value higher in each successive frame.
- R10: A cycle in which `wr_req` and `wr_ack` are both 1 is followed by a cycle with `wr_req` at 0. The fastest rate is one pixel every two cycles.
- R11: A free pixel takes exactly one clock cycle and no request. With blanking held active and acknowledges given at once, a frame lasts 2*(written pixels) + (free pixels) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_blank_n | input | 1 | Display blanking, low during blanking, asynchronous to clk |
| wr_ack | input | 1 | Slave accepted the current write |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W (19 at default) | Pixel address y*H_PIX + x |
| wr_data | output | CW (8) | Pixel colour |

## Verification
The bench builds the block with a 16 by 12 frame, a 3-row blue band and a free corner of 3 rows by 6 columns. That gives 192 pixels per frame: 174 written and 18 skipped. Many full frames, and so many steps of the frame counter, fit into a short run, and the diagonal crosses the map region and passes the free corner. The default synchronizer depth of two and colour-map mode 0 are kept, so the two-edge blanking latency and the x + y + offset colour rule are checked exactly. Acknowledge latencies from zero to three cycles and a windowed blanking pattern test the hold and gating behaviour.

// File: rtl/pw_pkg.sv
package pw_pkg;

   // class of a scan position; order gives no priority, the scene module does
   typedef enum logic [1:0] {
      PK_MAP  = 2'd0,
      PK_BLUE = 2'd1,
      PK_LINE = 2'd2,
      PK_SKIP = 2'd3
   } pix_kind_e;

   // index width for a count of n items, never below one bit
   function automatic int bits_for(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/pw_blank_sync.sv
module pw_blank_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic blank_n,
   output logic blank_act
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("pw_blank_sync: STAGES must be at least 2");
      end
   endgenerate

   // reset to the inactive level so no write starts out of reset
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], blank_n};
   end

   assign blank_act = ~chain[STAGES-1];

endmodule

// File: rtl/pw_raster_scan.sv
module pw_raster_scan #(
   parameter int H_PIX = 640,
   parameter int V_PIX = 480,
   parameter int CW    = 8,
   localparam int XW   = pw_pkg::bits_for(H_PIX),
   localparam int YW   = pw_pkg::bits_for(V_PIX)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          advance,
   output logic [XW-1:0] x,
   output logic [YW-1:0] y,
   output logic [CW-1:0] offset
);

   localparam logic [XW-1:0] X_LAST = XW'(H_PIX - 1);
   localparam logic [YW-1:0] Y_LAST = YW'(V_PIX - 1);

   logic row_end;
   logic frame_end;

   assign row_end   = (x == X_LAST);
   assign frame_end = row_end && (y == Y_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         x      <= '0;
         y      <= '0;
         offset <= '0;
      end else if (advance) begin
         if (row_end) begin
            x <= '0;
            if (frame_end) begin
               y      <= '0;
               offset <= offset + 1'b1;
            end else begin
               y <= y + 1'b1;
            end
         end else begin
            x <= x + 1'b1;
         end
      end
   end

   // R4
   scan_range_chk: assert property (@(posedge clk) disable iff (rst)
      (x <= X_LAST) && (y <= Y_LAST));

endmodule

// File: rtl/pw_scene_gen.sv
module pw_scene_gen #(
   parameter int H_PIX     = 640,
   parameter int V_PIX     = 480,
   parameter int CW        = 8,
   parameter int BLUE_ROWS = 120,
   parameter int FREE_ROWS = 120,
   parameter int FREE_COLS = 320,
   parameter int MAP_MODE  = 0,
   parameter logic [CW-1:0] BLUE_CODE = CW'(8'h03),
   parameter logic [CW-1:0] LINE_CODE = CW'(8'hFF),
   localparam int XW = pw_pkg::bits_for(H_PIX),
   localparam int YW = pw_pkg::bits_for(V_PIX)
) (
   input  logic [XW-1:0]          x,
   input  logic [YW-1:0]          y,
   input  logic [CW-1:0]          offset,
   output pw_pkg::pix_kind_e      kind,
   output logic [CW-1:0]          colour
);

   localparam int FREE_TOP = V_PIX - FREE_ROWS;

   int xi;
   int yi;
   logic in_blue;
   logic in_free;
   logic on_line;
   logic [CW-1:0] map_colour;

   assign xi      = int'(x);
   assign yi      = int'(y);
   assign in_blue = (yi < BLUE_ROWS);
   assign on_line = (xi == yi);

   generate
      if (FREE_ROWS == 0 || FREE_COLS == 0) begin : g_no_free
         assign in_free = 1'b0;
      end else begin : g_free
         assign in_free = (yi >= FREE_TOP) && (xi < FREE_COLS);
      end

      if (MAP_MODE == 0) begin : g_map_diag
         // gradient along both axes
         assign map_colour = CW'(xi + yi + int'(offset));
      end else if (MAP_MODE == 1) begin : g_map_cols
         // vertical stripes, y plays no part
         logic unused_y;
         assign unused_y   = ^y;
         assign map_colour = CW'(xi + int'(offset));
      end else begin : g_bad_mode
         $error("pw_scene_gen: MAP_MODE must be 0 or 1");
         assign map_colour = '0;
      end
   endgenerate

   // band first, then reserved corner, then line, then map
   always_comb begin
      if (in_blue) begin
         kind   = pw_pkg::PK_BLUE;
         colour = BLUE_CODE;
      end else if (in_free) begin
         kind   = pw_pkg::PK_SKIP;
         colour = '0;
      end else if (on_line) begin
         kind   = pw_pkg::PK_LINE;
         colour = LINE_CODE;
      end else begin
         kind   = pw_pkg::PK_MAP;
         colour = map_colour;
      end
   end

endmodule

// File: rtl/pixel_writer_master.sv
module pixel_writer_master #(
   parameter int H_PIX       = 640,
   parameter int V_PIX       = 480,
   parameter int CW          = 8,
   parameter int BLUE_ROWS   = 120,
   parameter int FREE_ROWS   = 120,
   parameter int FREE_COLS   = 320,
   parameter int MAP_MODE    = 0,
   parameter int SYNC_STAGES = 2,
   parameter logic [CW-1:0] BLUE_CODE = CW'(8'h03),
   parameter logic [CW-1:0] LINE_CODE = CW'(8'hFF),
   localparam int ADDR_W = pw_pkg::bits_for(H_PIX * V_PIX)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              vid_blank_n,
   input  logic              wr_ack,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [CW-1:0]     wr_data
);

   localparam int XW = pw_pkg::bits_for(H_PIX);
   localparam int YW = pw_pkg::bits_for(V_PIX);
   localparam logic [XW-1:0] X_LAST = XW'(H_PIX - 1);
   localparam logic [YW-1:0] Y_LAST = YW'(V_PIX - 1);

   generate
      if (H_PIX < 2 || V_PIX < 2) begin : g_bad_size
         $error("pixel_writer_master: frame must be at least 2x2");
      end
      if (BLUE_ROWS + FREE_ROWS > V_PIX) begin : g_bad_rows
         $error("pixel_writer_master: blue band and free band overlap");
      end
      if (FREE_COLS > H_PIX) begin : g_bad_cols
         $error("pixel_writer_master: free band wider than frame");
      end
      if (CW < 1) begin : g_bad_cw
         $error("pixel_writer_master: CW must be positive");
      end
   endgenerate

   logic              blank_act;
   logic              advance;
   logic [XW-1:0]     x;
   logic [YW-1:0]     y;
   logic [CW-1:0]     offset;
   pw_pkg::pix_kind_e kind;
   logic [CW-1:0]     colour;

   pw_blank_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst       (rst),
      .blank_n   (vid_blank_n),
      .blank_act (blank_act)
   );

   pw_raster_scan #(
      .H_PIX (H_PIX),
      .V_PIX (V_PIX),
      .CW    (CW)
   ) u_scan (
      .clk     (clk),
      .rst     (rst),
      .advance (advance),
      .x       (x),
      .y       (y),
      .offset  (offset)
   );

   pw_scene_gen #(
      .H_PIX     (H_PIX),
      .V_PIX     (V_PIX),
      .CW        (CW),
      .BLUE_ROWS (BLUE_ROWS),
      .FREE_ROWS (FREE_ROWS),
      .FREE_COLS (FREE_COLS),
      .MAP_MODE  (MAP_MODE),
      .BLUE_CODE (BLUE_CODE),
      .LINE_CODE (LINE_CODE)
   ) u_scene (
      .x      (x),
      .y      (y),
      .offset (offset),
      .kind   (kind),
      .colour (colour)
   );

   // move on when the pending write is accepted, or straight past a free pixel
   assign advance = wr_req ? wr_ack : (kind == pw_pkg::PK_SKIP);

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_req  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else if (wr_req) begin
         if (wr_ack) wr_req <= 1'b0;
      end else if (kind != pw_pkg::PK_SKIP && blank_act) begin
         wr_req  <= 1'b1;
         wr_addr <= ADDR_W'(int'(y) * H_PIX + int'(x));
         wr_data <= colour;
      end
   end

   // R2
   start_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(wr_req) |-> $past(blank_act));

   // R3
   hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

   // R10
   drop_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_req && wr_ack) |=> !wr_req);

   // R6
   no_free_write_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(wr_req) |-> ($past(kind) != pw_pkg::PK_SKIP));

   // R11
   skip_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      (!wr_req && kind == pw_pkg::PK_SKIP) |=>
         (!wr_req && !(x == $past(x) && y == $past(y))));

   // R9
   frame_step_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(x) == X_LAST && $past(y) == Y_LAST && x == '0 && y == '0) |->
         (offset == $past(offset) + 1'b1));

endmodule

// File: tb/pixel_writer_master_tb.sv
module pixel_writer_master_tb;

   localparam int CLK_PERIOD = 10;
   localparam int H   = 16;
   localparam int V   = 12;
   localparam int BR  = 3;
   localparam int FR  = 3;
   localparam int FC  = 6;
   localparam int AW  = $clog2(H * V);
   localparam int WRITES_PER_FRAME = H * V - FR * FC;
   localparam int FRAME_CYCLES     = 2 * WRITES_PER_FRAME + FR * FC;
   localparam int PROBE_ADDR       = 5 * H + 10;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          blank_n = 1'b1;
   logic          ack = 1'b0;
   logic          wr_req;
   logic [AW-1:0] wr_addr;
   logic [7:0]    wr_data;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pixel_writer_master #(
      .H_PIX     (H),
      .V_PIX     (V),
      .CW        (8),
      .BLUE_ROWS (BR),
      .FREE_ROWS (FR),
      .FREE_COLS (FC),
      .MAP_MODE  (0),
      .SYNC_STAGES (2),
      .BLUE_CODE (8'h03),
      .LINE_CODE (8'hFF)
   ) u_dut (
      .clk         (clk),
      .rst         (rst),
      .vid_blank_n (blank_n),
      .wr_ack      (ack),
      .wr_req      (wr_req),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // reference model state
   int m_s1, m_s2, m_req, m_addr, m_data, m_x, m_y, m_off;
   int wait_cnt = -1;
   int lfsr = 16'hACE1;
   int lat_max = 0;

   // directed-check state
   int cyc = 0;
   int prev_req = 0;
   int last_rise_addr = 1 << 20;
   int writes = 0;
   bit frame_seen = 1'b0;
   int last0 = -1;
   int probe_prev = -1;
   int bh0 = 1, bh1 = 1, bh2 = 1;
   int mode_cyc = 0;
   int rises_idle = 0;
   int in_reset = 1;

   function automatic int ref_kind(input int x, input int y);
      if (y < BR) return 1;
      if (y >= V - FR && x < FC) return 3;
      if (x == y) return 2;
      return 0;
   endfunction

   function automatic int ref_colour(input int x, input int y, input int off);
      case (ref_kind(x, y))
         1: return 8'h03;
         2: return 8'hFF;
         3: return 0;
         default: return (x + y + off) % 256;
      endcase
   endfunction

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic model_step();
      int adv, n1, n2;
      if (rst) begin
         m_s1 = 1; m_s2 = 1; m_req = 0; m_addr = 0; m_data = 0;
         m_x = 0; m_y = 0; m_off = 0;
      end else begin
         adv = 0;
         n1  = int'(blank_n);
         n2  = m_s1;
         if (m_req != 0) begin
            if (ack) begin m_req = 0; adv = 1; end
         end else if (ref_kind(m_x, m_y) == 3) begin
            adv = 1;
         end else if (m_s2 == 0) begin
            m_req  = 1;
            m_addr = m_y * H + m_x;
            m_data = ref_colour(m_x, m_y, m_off);
         end
         if (adv != 0) begin
            if (m_x == H - 1) begin
               m_x = 0;
               if (m_y == V - 1) begin
                  m_y = 0;
                  m_off = (m_off + 1) % 256;
               end else m_y++;
            end else m_x++;
         end
         m_s1 = n1;
         m_s2 = n2;
      end
   endtask

   task automatic on_rise(input int mode);
      int a, x, y, k;
      a = int'(wr_addr);
      x = a % H;
      y = a / H;
      k = ref_kind(x, y);
      // R6: a reserved corner pixel must never be requested
      check_eq("R6", "write into free corner", (k == 3) ? 1 : 0, 0);
      // R2: blanking seen low two edges before this rising edge
      check_eq("R2", "blank_n two edges before start", bh2, 0);
      if (mode == 3 && mode_cyc > 3) rises_idle++;
      case (k)
         1: check_eq("R5", "blue band colour", int'(wr_data), 8'h03);
         2: check_eq("R7", "diagonal colour", int'(wr_data), 8'hFF);
         0: check_eq("R8", "map colour", int'(wr_data), (x + y + m_off) % 256);
         default: ;
      endcase
      // R4: raster order and one write per non-free pixel per frame
      if (a < last_rise_addr) begin
         if (frame_seen) check_eq("R4", "writes per frame", writes, WRITES_PER_FRAME);
         frame_seen = 1'b1;
         writes = 0;
      end
      writes++;
      last_rise_addr = a;
      if (a == 0) begin
         // R11: frame time with free pixels taking one cycle each
         if (mode == 1 && last0 >= 0) check_eq("R11", "frame cycles", cyc - last0, FRAME_CYCLES);
         last0 = (mode == 1) ? cyc : -1;
      end
      if (a == PROBE_ADDR) begin
         // R9: colour of a fixed map pixel steps by one per frame
         if (probe_prev >= 0) check_eq("R9", "map pixel frame step", int'(wr_data), (probe_prev + 1) % 256);
         probe_prev = int'(wr_data);
      end
   endtask

   // one clock: compare at the falling edge, then drive and step the model
   task automatic cycle(input int mode, input logic rst_val);
      @(negedge clk);
      if (in_reset != 0) begin
         check_eq("R1", "wr_req in reset", int'(wr_req), 0);
         check_eq("R1", "wr_addr in reset", int'(wr_addr), 0);
         check_eq("R1", "wr_data in reset", int'(wr_data), 0);
      end
      check_eq("R2 R3 R10 R11", "wr_req vs model", int'(wr_req), m_req);
      check_eq("R3 R4", "wr_addr vs model", int'(wr_addr), m_addr);
      check_eq("R5 R7 R8", "wr_data vs model", int'(wr_data), m_data);
      if (wr_req && prev_req == 0) on_rise(mode);
      prev_req = int'(wr_req);
      cyc++;
      mode_cyc++;

      rst = rst_val;
      in_reset = int'(rst_val);
      case (mode)
         1: blank_n = 1'b0;
         2: blank_n = ((cyc % 20) < 7) ? 1'b0 : 1'b1;
         default: blank_n = 1'b1;
      endcase
      bh2 = bh1; bh1 = bh0; bh0 = int'(blank_n);

      if (m_req != 0 && !rst_val) begin
         if (wait_cnt < 0) begin
            lfsr = (lfsr & 1) ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
            wait_cnt = (lat_max == 0) ? 0 : (lfsr % (lat_max + 1));
         end
         if (wait_cnt == 0) begin ack = 1'b1; wait_cnt = -1; end
         else begin ack = 1'b0; wait_cnt--; end
      end else begin
         ack = 1'b0;
      end
      model_step();
   endtask

   initial begin
      model_step();
      for (int i = 0; i < 4; i++) cycle(0, 1'b1);
      // phase 1: blanking held, immediate acknowledge
      mode_cyc = 0; lat_max = 0;
      for (int i = 0; i < 3000; i++) cycle(1, 1'b0);
      // phase 2: blanking windows, acknowledge after 0..3 cycles
      mode_cyc = 0; lat_max = 3; last0 = -1;
      for (int i = 0; i < 6000; i++) cycle(2, 1'b0);
      // phase 3: no blanking at all
      mode_cyc = 0;
      for (int i = 0; i < 300; i++) cycle(3, 1'b0);
      check_eq("R2", "starts outside blanking", rises_idle, 0);
      check_eq("R9", "frames completed", (m_off > 6) ? 1 : 0, 1);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule